// File: doc/BRIEF.md
# Translation Entry Update Engine

This block keeps the translation entries of a small set of DMA windows and changes them on command. Each window has a 32-bit identifier, a fixed bus offset and a fixed number of entries. Each entry covers one page of the window's bus address space. A command names a window, a bus address and an operand. The engine then does one of four things: it writes one entry, reads one entry back, writes the same value into a run of consecutive entries, or fetches a list of entry values from memory and writes them into consecutive entries.

Commands arrive over a valid/ready handshake, and the engine works on one command at a time. It checks the arguments first. It then steps through the pages one per cycle and ends with a single done pulse that carries the status and, for a read, the entry. Every entry it writes also produces a one-cycle invalidation notice. Downstream caches of translations use that notice to drop a stale mapping. List elements are fetched one at a time through a simple read request/response port.

Top module: `xlate_update_engine`

## Requirements
- R1: A command whose window identifier has any of bits 63:32 set, or whose low 32 bits name no configured window, completes one cycle after acceptance with `status_err`=1 and writes nothing. Window w has identifier 0x1000+w and bus offset w·2^32. There are 2 windows of 16 entries each, and each page is 4 KiB.
- R2: The target address is first rounded down to a page boundary. The entry index is (address − window offset) >> 12, using unsigned arithmetic. An index of 16 or more gives `status_err`=1 and writes nothing.
- R3: A single write stores `cmd_data` in the indexed entry. A read returns that entry on `rd_data` with `status_err`=0. A read that fails returns `rd_data`=0 with `status_err`=1. `cmd_op` encodes 0 for a single write, 1 for a read, 2 for a fill and 3 for a list write.
- R4: A fill writes `cmd_data` into `cmd_count` consecutive pages, moving the address up by one page per step. It is rejected one cycle after acceptance, with no writes, if `cmd_count` exceeds the entry count.
- R5: A list write is rejected one cycle after acceptance if `cmd_count` exceeds 512 or if `cmd_data` (the list address) is not 4 KiB aligned. Element i is requested at list address + 8·i. The response puts the byte at the lowest address in bits 7:0, and the element is read big-endian, so that byte becomes bits 63:56 of the entry.
- R6: A fill or a list write stops at the first page whose index is out of range and reports `status_err`=1. The entries it wrote before that page stay written.
- R7: Each entry write gives one `inv_valid` pulse. The pulse carries (address − offset) with the page offset cleared, the entry with the page offset cleared, the mask 0xFFF, and a permission equal to entry bits 1:0 (0 none, 1 read, 2 write, 3 both).
- R8: A fill or list write with `cmd_count`=0 completes one cycle after acceptance with `status_err`=1 and writes nothing.
- R9: `cmd_ready` is high only while idle. Each accepted command gives exactly one `done` pulse. That pulse comes k+1 cycles after acceptance, where k is the number of pages attempted, or 1 cycle after acceptance for a command rejected at acceptance.
- R10: After reset all entries read as zero, and `cmd_ready`=1 with `done`, `inv_valid` and `mem_req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and accepting |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list write |
| cmd_win | input | 64 | Window identifier |
| cmd_addr | input | 64 | Bus address of the first page |
| cmd_data | input | 64 | Entry value, or list address for a list write |
| cmd_count | input | 64 | Page count for fill and list write |
| done | output | 1 | One-cycle completion pulse |
| status_err | output | 1 | 1 = parameter error, valid with done |
| rd_data | output | 64 | Entry returned by a read |
| mem_req_valid | output | 1 | List element read request |
| mem_req_addr | output | 64 | Address of the requested element |
| mem_rsp_valid | input | 1 | Element data valid |
| mem_rsp_data | input | 64 | Element bytes, lowest address in bits 7:0 |
| inv_valid | output | 1 | Invalidation notice for a written entry |
| inv_iova | output | 64 | Page-aligned offset of the page inside the window |
| inv_xlat | output | 64 | Page-aligned translated address |
| inv_mask | output | 64 | Offset-within-page mask |
| inv_perm | output | 2 | Permission decoded from entry bits 1:0 |

## Verification
A wrong entry index or a lost write stays hidden until a later read of that entry, so the bench follows writes with reads and compares every notice on the cycle it appears. A loop counter or a page pointer that is off shows up at once. In that case the done pulse arrives on the wrong cycle, an extra or missing notice appears, or a request goes to the wrong list address. The reference model checks each of these on every clock. Acceptance-time rejections give themselves away one cycle after acceptance: they show either as a late done or as a notice that should not exist.

// File: rtl/xlate_update_engine.sv
module xlate_update_engine #(
  parameter int          NWIN       = 2,
  parameter int          ENTRIES    = 16,
  parameter int          PSHIFT     = 12,
  parameter logic [31:0] ID_BASE    = 32'h0000_1000,
  parameter logic [63:0] OFF_STRIDE = 64'h1_0000_0000,
  parameter int          MAX_LIST   = 512,
  parameter int          LIST_ALIGN = 12
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [63:0] cmd_win,
  input  logic [63:0] cmd_addr,
  input  logic [63:0] cmd_data,
  input  logic [63:0] cmd_count,
  output logic        done,
  output logic        status_err,
  output logic [63:0] rd_data,
  output logic        mem_req_valid,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        inv_valid,
  output logic [63:0] inv_iova,
  output logic [63:0] inv_xlat,
  output logic [63:0] inv_mask,
  output logic [1:0]  inv_perm
);
  localparam int TOTAL = NWIN * ENTRIES;
  localparam int TW    = $clog2(TOTAL);
  localparam int IW    = $clog2(ENTRIES);
  localparam int WW    = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int CMAX  = (MAX_LIST > ENTRIES) ? MAX_LIST : ENTRIES;
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [63:0] PAGE  = 64'd1 << PSHIFT;
  localparam logic [63:0] PMASK = ~(PAGE - 64'd1);
  localparam logic [1:0] OP_PUT = 2'd0, OP_GET = 2'd1, OP_FILL = 2'd2, OP_LIST = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_FETCH} state_t;
  state_t state;

  logic [63:0]   tab [TOTAL];
  logic [1:0]    op_q;
  logic [WW-1:0] win_q;
  logic [63:0]   addr_q, val_q, ptr_q;
  logic [CW-1:0] left_q;

  logic [31:0] id_off;
  logic        win_hit, count_bad, reject;
  logic [63:0] diff, pidx, swp, wval;
  logic        in_rng, step;
  logic [TW-1:0] slot;

  assign id_off  = cmd_win[31:0] - ID_BASE;
  assign win_hit = (cmd_win[63:32] == 32'd0) && (id_off < 32'(NWIN));

  always_comb begin
    case (cmd_op)
      OP_FILL: count_bad = (cmd_count == 64'd0) || (cmd_count > 64'(ENTRIES));
      OP_LIST: count_bad = (cmd_count == 64'd0) || (cmd_count > 64'(MAX_LIST)) ||
                           (cmd_data[LIST_ALIGN-1:0] != '0);
      default: count_bad = 1'b0;
    endcase
  end
  assign reject = !win_hit || count_bad;

  assign diff   = addr_q - (64'(win_q) * OFF_STRIDE);
  assign pidx   = diff >> PSHIFT;
  assign in_rng = pidx < 64'(ENTRIES);
  assign slot   = TW'(win_q) * TW'(ENTRIES) + TW'(pidx[IW-1:0]);

  always_comb begin
    for (int b = 0; b < 8; b++) swp[8*b +: 8] = mem_rsp_data[8*(7-b) +: 8];
  end
  assign wval = (op_q == OP_LIST) ? swp : val_q;
  assign step = (state == S_EXEC) || (state == S_FETCH && mem_rsp_valid);

  assign cmd_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_FETCH);
  assign mem_req_addr  = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done <= 1'b0; status_err <= 1'b0; rd_data <= '0;
      inv_valid <= 1'b0; inv_iova <= '0; inv_xlat <= '0; inv_mask <= '0; inv_perm <= '0;
      op_q <= '0; win_q <= '0; addr_q <= '0; val_q <= '0; ptr_q <= '0; left_q <= '0;
      for (int i = 0; i < TOTAL; i++) tab[i] <= '0;
    end else begin
      done      <= 1'b0;
      inv_valid <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          win_q  <= id_off[WW-1:0];
          addr_q <= cmd_addr & PMASK;
          val_q  <= cmd_data;
          ptr_q  <= cmd_data;
          left_q <= (cmd_op == OP_PUT || cmd_op == OP_GET) ? CW'(1) : cmd_count[CW-1:0];
          if (reject) begin
            done <= 1'b1; status_err <= 1'b1; rd_data <= '0;
          end else begin
            state <= (cmd_op == OP_LIST) ? S_FETCH : S_EXEC;
          end
        end
        default: if (step) begin
          if (!in_rng) begin
            done <= 1'b1; status_err <= 1'b1; rd_data <= '0; state <= S_IDLE;
          end else if (op_q == OP_GET) begin
            done <= 1'b1; status_err <= 1'b0; rd_data <= tab[slot]; state <= S_IDLE;
          end else begin
            tab[slot] <= wval;
            inv_valid <= 1'b1;
            inv_iova  <= diff & PMASK;
            inv_xlat  <= wval & PMASK;
            inv_mask  <= ~PMASK;
            inv_perm  <= wval[1:0];
            left_q    <= left_q - CW'(1);
            addr_q    <= addr_q + PAGE;
            ptr_q     <= ptr_q + 64'd8;
            if (left_q == CW'(1)) begin
              done <= 1'b1; status_err <= 1'b0; rd_data <= '0; state <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  assert_list_req_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'd0)) else $error("list request misaligned");

  assert_notice_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (((inv_iova | inv_xlat) & inv_mask) == 64'd0)) else $error("notice not page aligned");

  assert_notice_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> $past(state != S_IDLE)) else $error("notice from idle engine");

  assert_error_no_notice_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status_err) |-> !inv_valid) else $error("write reported with error");

  assert_done_returns_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready) else $error("done while busy");

  assert_accept_goes_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (done || !cmd_ready)) else $error("accept ignored");
endmodule

// File: tb/tb_xlate_update_engine.sv
module tb_xlate_update_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, done, status_err;
  logic mem_req_valid, mem_rsp_valid, inv_valid;
  logic [1:0] cmd_op, inv_perm;
  logic [63:0] cmd_win, cmd_addr, cmd_data, cmd_count, rd_data;
  logic [63:0] mem_req_addr, mem_rsp_data, inv_iova, inv_xlat, inv_mask;

  xlate_update_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_win(cmd_win), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_count(cmd_count), .done(done), .status_err(status_err), .rd_data(rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .inv_valid(inv_valid), .inv_iova(inv_iova), .inv_xlat(inv_xlat),
    .inv_mask(inv_mask), .inv_perm(inv_perm));

  int checks = 0, errors = 0;
  logic [63:0] mdl [2][16];
  logic [63:0] lmem [logic [63:0]];
  logic [63:0] q_iova [$], q_xlat [$], q_req [$];
  logic [1:0]  q_perm [$];

  function automatic logic [63:0] bswap(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory responder: answers every request seen at a falling edge, checks its address
  always @(negedge clk) begin
    if (rst_n && mem_req_valid) begin
      logic [63:0] e;
      e = (q_req.size() > 0) ? q_req.pop_front() : 64'hDEAD;
      chk(mem_req_addr == e, "R5", "list request address", mem_req_addr, e);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = bswap(lmem.exists(mem_req_addr) ? lmem[mem_req_addr] : 64'd0);
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 64'd0;
    end
  end

  task automatic run(input logic [1:0] op, input logic [63:0] win, input logic [63:0] addr,
                     input logic [63:0] data, input logic [63:0] cnt, input string tag);
    bit upfront, exp_err, got;
    int w, n, processed, lat, cycles;
    logic [63:0] a, d, v, idx, exp_rd, e;
    upfront = !((win[63:32] == 0) && (win[31:0] >= 32'h1000) && (win[31:0] < 32'h1002));
    w = int'(win[31:0] - 32'h1000);
    if (op == 2 && (cnt == 0 || cnt > 16)) upfront = 1;
    if (op == 3 && (cnt == 0 || cnt > 512 || data[11:0] != 0)) upfront = 1;
    exp_rd = 0; exp_err = 1; processed = 0;
    if (!upfront) begin
      exp_err = 0;
      n = (op < 2) ? 1 : int'(cnt);
      a = addr & ~64'hFFF;
      for (int i = 0; i < n; i++) begin
        processed++;
        v = data;
        if (op == 3) begin
          q_req.push_back(data + 64'(8 * i));
          v = lmem.exists(data + 64'(8 * i)) ? lmem[data + 64'(8 * i)] : 64'd0;
        end
        d = a - (64'(w) << 32);
        idx = d >> 12;
        if (idx >= 16) begin exp_err = 1; break; end
        if (op == 1) exp_rd = mdl[w][idx[3:0]];
        else begin
          mdl[w][idx[3:0]] = v;
          q_iova.push_back(d & ~64'hFFF);
          q_xlat.push_back(v & ~64'hFFF);
          q_perm.push_back(v[1:0]);
        end
        a += 64'd4096;
      end
    end
    lat = upfront ? 1 : processed + 1;

    chk(cmd_ready == 1'b1, tag, "ready before command", 64'(cmd_ready), 64'd1);
    cmd_valid = 1'b1; cmd_op = op; cmd_win = win; cmd_addr = addr;
    cmd_data = data; cmd_count = cnt;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cycles = 0; got = 0;
    while (!got && cycles < 3000) begin
      cycles++;
      if (inv_valid) begin
        if (q_iova.size() == 0) chk(0, tag, "unexpected notice R7", inv_iova, 64'd0);
        else begin
          e = q_iova.pop_front(); chk(inv_iova == e, tag, "notice iova R7", inv_iova, e);
          e = q_xlat.pop_front(); chk(inv_xlat == e, tag, "notice xlat R7", inv_xlat, e);
          e = 64'(q_perm.pop_front()); chk(64'(inv_perm) == e, tag, "notice perm R7", 64'(inv_perm), e);
          chk(inv_mask == 64'hFFF, tag, "notice mask R7", inv_mask, 64'hFFF);
        end
      end
      if (done) got = 1;
      else @(negedge clk);
    end
    chk(got, tag, "done seen R9", 64'(got), 64'd1);
    chk(status_err == exp_err, tag, "status", 64'(status_err), 64'(exp_err));
    chk(rd_data == exp_rd, tag, "read data", rd_data, exp_rd);
    chk(cycles == lat, tag, "done latency R9", 64'(cycles), 64'(lat));
    chk(cmd_ready == 1'b1, tag, "ready with done R9", 64'(cmd_ready), 64'd1);
    chk(q_iova.size() == 0, tag, "missing notices R7", 64'(q_iova.size()), 64'd0);
    chk(q_req.size() == 0, tag, "missing list requests R5", 64'(q_req.size()), 64'd0);
    q_iova.delete(); q_xlat.delete(); q_perm.delete(); q_req.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [63:0] W0 = 64'h1000, W1 = 64'h1001, B1 = 64'h1_0000_0000;

  initial begin
    for (int w = 0; w < 2; w++) for (int i = 0; i < 16; i++) mdl[w][i] = 64'd0;
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_win = 0; cmd_addr = 0; cmd_data = 0; cmd_count = 0;
    mem_rsp_valid = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !done && !inv_valid && !mem_req_valid, "R10", "idle after reset",
        {60'd0, cmd_ready, done, inv_valid, mem_req_valid}, 64'h8);
    run(1, W0, 64'h3000, 0, 0, "R10_get_cleared");

    run(0, W0, 64'h3123, 64'hABCD_E003, 0, "R2_put_unaligned");
    run(1, W0, 64'h3FFF, 0, 0, "R3_get_back");
    run(0, W1, B1 + 64'h5000, 64'h1234_5001, 0, "R3_put_win1");
    run(1, W1, B1 + 64'h5010, 0, 0, "R3_get_win1");

    run(0, 64'h1_0000_1000, 64'h3000, 64'h7777_7003, 0, "R1_high_bits");
    run(0, 64'h2000, 64'h3000, 64'h7777_7003, 0, "R1_unknown_id");
    run(1, W0, 64'h3000, 0, 0, "R1_entry_untouched");

    run(0, W0, 64'h10000, 64'h5555_5002, 0, "R2_index_16");
    run(0, W1, 64'h5000, 64'h5555_5002, 0, "R2_below_offset");
    run(1, W0, 64'h20000, 0, 0, "R3_get_out_of_range");

    run(2, W0, 64'h8000, 64'hCAFE_0002, 4, "R4_fill_four");
    run(1, W0, 64'hB000, 0, 0, "R4_fill_last");
    run(1, W0, 64'hC000, 0, 0, "R4_fill_beyond");
    run(2, W0, 64'h0, 64'h9999_9001, 17, "R4_fill_too_long");
    run(1, W0, 64'h0, 0, 0, "R4_no_write_after_reject");
    run(2, W1, B1, 64'h4444_4003, 16, "R4_fill_whole_window");
    run(1, W1, B1 + 64'hF000, 0, 0, "R4_whole_last");

    run(2, W0, 64'hE000, 64'hBEEF_0001, 4, "R6_fill_overrun");
    run(1, W0, 64'hF000, 0, 0, "R6_kept_write");

    run(2, W0, 64'h1000, 64'h1111_1003, 0, "R8_fill_zero");
    run(3, W0, 64'h1000, 64'h40000, 0, "R8_list_zero");
    run(1, W0, 64'h1000, 0, 0, "R8_no_write");

    lmem[64'h40000] = 64'h0102_0304_0506_7003;
    lmem[64'h40008] = 64'hA0B0_C0D0_E0F0_1001;
    lmem[64'h40010] = 64'h0000_0000_0000_2002;
    run(3, W0, 64'h4000, 64'h40000, 3, "R5_list_three");
    run(1, W0, 64'h4000, 0, 0, "R5_big_endian_elem0");
    run(1, W0, 64'h6000, 0, 0, "R5_elem2");
    run(3, W0, 64'h4000, 64'h40000, 513, "R5_list_too_long");
    run(3, W0, 64'h4000, 64'h40008, 2, "R5_list_misaligned");
    run(3, W1, B1 + 64'hE000, 64'h40000, 3, "R6_list_overrun");
    run(1, W1, B1 + 64'hF000, 0, 0, "R6_list_kept");
    run(0, W0, 64'h7000, 64'hFFFF_FFFF_FFFF_F000, 0, "R7_perm_none");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule